// File: doc/BRIEF.md
# SMBus Timing Guard

This block sits beside a two-wire management bus controller and watches the clock and data lines, sampled with the system clock. Each line passes through a two-flop synchronizer and a glitch filter. The block then finds START and STOP conditions and tracks whether a message is in progress. It enforces the bus timing limits that the controller must obey. It does not shift data, decode addresses or arbitrate.

The controller asks to pull a line low through a request input. The guard turns that request into a registered low-enable for the open-drain pad. The guard may withhold the enable:
- when the device has held the clock low for too long, or
- after a bus stall timeout.

The guard also measures the low time the device adds to the clock:
- per byte, while the device is master;
- per message, while it is slave.

As master, it flags any clock phase that is too slow. After the device gives up mastership, a new mastership request is held off for a fixed gap. All limits are parameters counted in system-clock cycles. The defaults assume a 10 MHz clock.

Top module: `smb_timing_guard`

## Requirements
- R1: A registered one-cycle pulse `start_det` marks SDA falling while SCL is high. A pulse `stop_det` marks SDA rising while SCL is high. An SDA change while SCL is low produces neither pulse. `bus_idle` is high only when no message is open and both filtered lines are high.
- R2: A low pulse on either line that lasts fewer than `FILT_LEN` clock cycles produces no event. A pulse of `FILT_LEN` cycles or more is accepted.
- R3: `scl_oe` is never high for more than `WDOG_CYC` consecutive cycles. When the limit is reached, `scl_oe` drops and stays low while `scl_drv_req` stays high. `wdog_trip` is high during that forced release and clears once `scl_drv_req` drops.
- R4: A `rel_master` pulse applied at clock edge E0 holds `grant_master` low through edge E(`HOLDOFF_CYC`). From edge E(`HOLDOFF_CYC`+1) on, `grant_master` follows `req_master`, one cycle late. A request made during the gap is deferred, not dropped.
- R5: While `is_master` is high, the device's own SCL-low cycles are summed per byte. When the sum exceeds `MEXT_CYC`, the sticky flag `mext_viol` is set. The sum clears on the ninth SCL rising edge of a byte and on every START.
- R6: While `is_master` is low and a message is open, the device's own SCL-low cycles are summed. When the sum exceeds `SEXT_CYC`, the sticky flag `sext_viol` is set. The sum clears on START and on STOP.
- R7: While `is_master` is high and a message is open, any SCL low or high phase longer than `HALF_CYC` cycles sets the sticky flag `underspeed`. As slave, no such flag is raised.
- R8: When SCL stays low for `TIMEOUT_CYC` cycles, `timeout_rst` pulses for exactly one cycle. Its effects are:
  - both low-enables are released and stay released until both drive requests drop;
  - the open message is closed;
  - the accumulators and the holdoff are cleared.
- R9: `timeout_sticky` is set by the timeout pulse and stays set until `clr_status` is pulsed. `clr_status` also clears `mext_viol`, `sext_viol` and `underspeed`.
- R10: After reset, every output is low except `bus_idle`, which is high.
- R11: A `rel_master` pulse in the same cycle as the timeout reset restarts the holdoff instead of being cleared by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed clock line |
| sda_i | input | 1 | Sensed data line |
| is_master | input | 1 | Device currently acts as master |
| scl_drv_req | input | 1 | Controller asks to pull SCL low |
| sda_drv_req | input | 1 | Controller asks to pull SDA low |
| rel_master | input | 1 | Pulse: mastership given up |
| req_master | input | 1 | Level: controller wants mastership |
| clr_status | input | 1 | Pulse: clear sticky flags |
| scl_oe | output | 1 | SCL low-enable for the pad |
| sda_oe | output | 1 | SDA low-enable for the pad |
| grant_master | output | 1 | Mastership request may proceed |
| start_det | output | 1 | START seen (one cycle) |
| stop_det | output | 1 | STOP seen (one cycle) |
| bus_idle | output | 1 | No message open, both lines high |
| wdog_trip | output | 1 | SCL hold watchdog forcing release |
| mext_viol | output | 1 | Master per-byte stretch budget exceeded |
| sext_viol | output | 1 | Slave per-message stretch budget exceeded |
| underspeed | output | 1 | Master clock phase too long |
| timeout_rst | output | 1 | One-cycle bus timeout reset |
| timeout_sticky | output | 1 | Timeout seen since last clear |

## Verification
The stall timeout clears the mastership holdoff. A release of mastership loads that same holdoff. Both can land on the same clock edge.

The bench provokes this by holding SCL low until `timeout_rst` is seen. In that very cycle it pulses `rel_master` while `req_master` stays high. The check then requires `grant_master` to stay low well into the gap and to rise only after the full holdoff. A design in which the clear wins would grant within a cycle or two.

// File: rtl/smb_guard_pkg.sv
package smb_guard_pkg;

  // Index of each line inside the raw/filtered line vectors
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;

  // Registered bus events produced by the condition detector
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic in_msg;
  } bus_evt_t;

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;

  // Two-flop synchronizer, then a history window; the output moves
  // only when the whole window agrees on the new level.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      if (&hist_q)
        line_o <= 1'b1;
      else if (~|hist_q)
        line_o <= 1'b0;
    end
  end

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect
  import smb_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_f,
  input  logic     sda_f,
  input  logic     tout_clr,
  output bus_evt_t evt,
  output logic     bus_idle
);

  logic scl_q, sda_q;
  logic start_c, stop_c, rise_c, in_msg_n;

  always_comb begin
    start_c = scl_q & scl_f & sda_q & ~sda_f;
    stop_c  = scl_q & scl_f & ~sda_q & sda_f;
    rise_c  = ~scl_q & scl_f;
    if (tout_clr)     in_msg_n = 1'b0;
    else if (start_c) in_msg_n = 1'b1;
    else if (stop_c)  in_msg_n = 1'b0;
    else              in_msg_n = evt.in_msg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      evt      <= '0;
      bus_idle <= 1'b1;
    end else begin
      scl_q        <= scl_f;
      sda_q        <= sda_f;
      evt.start    <= start_c;
      evt.stop     <= stop_c;
      evt.scl_rise <= rise_c;
      evt.in_msg   <= in_msg_n;
      bus_idle     <= ~in_msg_n & scl_f & sda_f;
    end
  end

  // R1: a freshly seen START never coexists with an idle indication
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (rst)
    evt.start |-> !bus_idle);

endmodule

// File: rtl/smb_holdoff.sv
module smb_holdoff #(
  parameter int HOLDOFF_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic rel_master,
  input  logic req_master,
  input  logic tout_clr,
  output logic grant_master
);

  localparam int HW = $clog2(HOLDOFF_CYC + 1);

  logic [HW-1:0] gap_cnt;

  // Release loads the gap; it wins over a same-cycle timeout clear (R11)
  always_ff @(posedge clk) begin
    if (rst)
      gap_cnt <= '0;
    else if (rel_master)
      gap_cnt <= HW'(HOLDOFF_CYC);
    else if (tout_clr)
      gap_cnt <= '0;
    else if (gap_cnt != '0)
      gap_cnt <= gap_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) grant_master <= 1'b0;
    else     grant_master <= req_master & (gap_cnt == '0) & ~rel_master;
  end

  // R4: two edges after a release the grant is still withheld
  assert_holdoff_gap_R4: assert property (@(posedge clk) disable iff (rst)
    rel_master |=> ##1 !grant_master);

endmodule

// File: rtl/smb_stretch_meter.sv
module smb_stretch_meter
  import smb_guard_pkg::*;
#(
  parameter int WDOG_CYC = 19000,
  parameter int MEXT_CYC = 100000,
  parameter int SEXT_CYC = 250000,
  parameter int HALF_CYC = 500
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     is_master,
  input  logic     own_low,
  input  logic     scl_drv_req,
  input  logic     scl_f,
  input  bus_evt_t evt,
  input  logic     tout_clr,
  input  logic     clr_status,
  output logic     wdog_block,
  output logic     mext_viol,
  output logic     sext_viol,
  output logic     underspeed
);

  localparam int WD_W = $clog2(WDOG_CYC + 1);
  localparam int MX_W = $clog2(MEXT_CYC + 2);
  localparam int SX_W = $clog2(SEXT_CYC + 2);
  localparam int PH_W = $clog2(HALF_CYC + 1);
  localparam int BITS_PER_BYTE = 9;

  // ---------------- SCL hold watchdog (R3) ----------------
  logic [WD_W-1:0] wd_cnt;
  logic            wd_set;

  assign wd_set = own_low && scl_drv_req && (wd_cnt == WD_W'(WDOG_CYC - 2));

  always_ff @(posedge clk) begin
    if (rst || !own_low)
      wd_cnt <= '0;
    else if (wd_cnt != WD_W'(WDOG_CYC))
      wd_cnt <= wd_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             wdog_block <= 1'b0;
    else if (wdog_block) wdog_block <= scl_drv_req;
    else                 wdog_block <= wd_set;
  end

  // ---------------- Per-byte master budget (R5) ----------------
  logic [3:0]      bit_cnt;
  logic            byte_end, m_add, m_clr, m_over;
  logic [MX_W-1:0] byte_acc;

  assign byte_end = evt.scl_rise && (bit_cnt == 4'(BITS_PER_BYTE - 1));
  assign m_add    = own_low && is_master;
  assign m_clr    = tout_clr || evt.start || byte_end;
  assign m_over   = m_add && !m_clr && (byte_acc == MX_W'(MEXT_CYC));

  always_ff @(posedge clk) begin
    if (rst || tout_clr || evt.start)
      bit_cnt <= '0;
    else if (evt.scl_rise)
      bit_cnt <= byte_end ? 4'd0 : bit_cnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || m_clr)
      byte_acc <= '0;
    else if (m_add && byte_acc != MX_W'(MEXT_CYC + 1))
      byte_acc <= byte_acc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             mext_viol <= 1'b0;
    else if (m_over)     mext_viol <= 1'b1;
    else if (clr_status) mext_viol <= 1'b0;
  end

  // ---------------- Per-message slave budget (R6) ----------------
  logic            s_add, s_clr, s_over;
  logic [SX_W-1:0] msg_acc;

  assign s_add  = own_low && !is_master && evt.in_msg;
  assign s_clr  = tout_clr || evt.start || evt.stop;
  assign s_over = s_add && !s_clr && (msg_acc == SX_W'(SEXT_CYC));

  always_ff @(posedge clk) begin
    if (rst || s_clr)
      msg_acc <= '0;
    else if (s_add && msg_acc != SX_W'(SEXT_CYC + 1))
      msg_acc <= msg_acc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             sext_viol <= 1'b0;
    else if (s_over)     sext_viol <= 1'b1;
    else if (clr_status) sext_viol <= 1'b0;
  end

  // ---------------- Minimum clock rate check (R7) ----------------
  logic            scl_p, ph_run, us_set;
  logic [PH_W-1:0] ph_cnt;

  assign ph_run = is_master && evt.in_msg && (scl_f == scl_p);
  assign us_set = ph_run && (ph_cnt == PH_W'(HALF_CYC));

  always_ff @(posedge clk) begin
    if (rst) scl_p <= 1'b1;
    else     scl_p <= scl_f;
  end

  always_ff @(posedge clk) begin
    if (rst || !ph_run)
      ph_cnt <= '0;
    else if (ph_cnt != PH_W'(HALF_CYC))
      ph_cnt <= ph_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             underspeed <= 1'b0;
    else if (us_set)     underspeed <= 1'b1;
    else if (clr_status) underspeed <= 1'b0;
  end

  // R3: once the watchdog blocks, the pad enable is low from the next cycle on
  assert_wdog_release_R3: assert property (@(posedge clk) disable iff (rst)
    wdog_block |=> !own_low);

endmodule

// File: rtl/smb_timing_guard.sv
module smb_timing_guard
  import smb_guard_pkg::*;
#(
  parameter int FILT_LEN    = 3,
  parameter int HOLDOFF_CYC = 500,
  parameter int WDOG_CYC    = 19000,
  parameter int TIMEOUT_CYC = 250000,
  parameter int MEXT_CYC    = 100000,
  parameter int SEXT_CYC    = 250000,
  parameter int HALF_CYC    = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic is_master,
  input  logic scl_drv_req,
  input  logic sda_drv_req,
  input  logic rel_master,
  input  logic req_master,
  input  logic clr_status,
  output logic scl_oe,
  output logic sda_oe,
  output logic grant_master,
  output logic start_det,
  output logic stop_det,
  output logic bus_idle,
  output logic wdog_trip,
  output logic mext_viol,
  output logic sext_viol,
  output logic underspeed,
  output logic timeout_rst,
  output logic timeout_sticky
);

  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

  logic [NUM_LINES-1:0] raw_lines, filt_lines;
  logic                 scl_f, sda_f;
  bus_evt_t             evt;
  logic                 wdog_block;
  logic                 tout_hold;
  logic [TO_W-1:0]      low_cnt;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    smb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[LINE_SCL];
  assign sda_f = filt_lines[LINE_SDA];

  smb_cond_detect u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .tout_clr (timeout_rst),
    .evt      (evt),
    .bus_idle (bus_idle)
  );

  smb_stretch_meter #(
    .WDOG_CYC (WDOG_CYC),
    .MEXT_CYC (MEXT_CYC),
    .SEXT_CYC (SEXT_CYC),
    .HALF_CYC (HALF_CYC)
  ) u_meter (
    .clk         (clk),
    .rst         (rst),
    .is_master   (is_master),
    .own_low     (scl_oe),
    .scl_drv_req (scl_drv_req),
    .scl_f       (scl_f),
    .evt         (evt),
    .tout_clr    (timeout_rst),
    .clr_status  (clr_status),
    .wdog_block  (wdog_block),
    .mext_viol   (mext_viol),
    .sext_viol   (sext_viol),
    .underspeed  (underspeed)
  );

  smb_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .rel_master   (rel_master),
    .req_master   (req_master),
    .tout_clr     (timeout_rst),
    .grant_master (grant_master)
  );

  assign start_det = evt.start;
  assign stop_det  = evt.stop;
  assign wdog_trip = wdog_block;

  // Bus stall timer on the filtered clock line (R8)
  always_ff @(posedge clk) begin
    if (rst || scl_f)
      low_cnt <= '0;
    else if (low_cnt != TO_W'(TIMEOUT_CYC))
      low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout_rst    <= 1'b0;
      tout_hold      <= 1'b0;
      timeout_sticky <= 1'b0;
    end else begin
      timeout_rst <= !scl_f && (low_cnt == TO_W'(TIMEOUT_CYC - 1));
      tout_hold   <= timeout_rst | (tout_hold & (scl_drv_req | sda_drv_req));
      if (timeout_rst)     timeout_sticky <= 1'b1;
      else if (clr_status) timeout_sticky <= 1'b0;
    end
  end

  // Registered open-drain low-enables
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= scl_drv_req & ~wdog_block & ~tout_hold & ~timeout_rst;
      sda_oe <= sda_drv_req & ~tout_hold & ~timeout_rst;
    end
  end

  // ---------------- Assertions ----------------
  // Independent run-length monitor of the SCL enable for R3
  logic [$clog2(WDOG_CYC + 2)-1:0] chk_run;
  always_ff @(posedge clk) begin
    if (rst || !scl_oe)
      chk_run <= '0;
    else if (chk_run != ($clog2(WDOG_CYC + 2))'(WDOG_CYC + 1))
      chk_run <= chk_run + 1'b1;
  end

  assert_wdog_hold_R3: assert property (@(posedge clk) disable iff (rst)
    chk_run <= ($clog2(WDOG_CYC + 2))'(WDOG_CYC));

  assert_tout_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    timeout_rst |=> !timeout_rst);

  assert_tout_release_R8: assert property (@(posedge clk) disable iff (rst)
    timeout_rst |=> (!scl_oe && !sda_oe));

  assert_tout_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    timeout_rst |=> timeout_sticky);

endmodule

// File: tb/smb_timing_guard_tb_top.sv
module smb_timing_guard_tb_top;

  localparam int T_FILT = 3;
  localparam int T_HOLD = 40;
  localparam int T_WDOG = 100;
  localparam int T_TOUT = 300;
  localparam int T_MEXT = 60;
  localparam int T_SEXT = 150;
  localparam int T_HALF = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b0, scl_drv_req = 1'b0, sda_drv_req = 1'b0;
  logic rel_master = 1'b0, req_master = 1'b0, clr_status = 1'b0;
  logic tb_scl_pull = 1'b0, tb_sda_pull = 1'b0;
  logic scl_i, sda_i;
  logic scl_oe, sda_oe, grant_master, start_det, stop_det, bus_idle;
  logic wdog_trip, mext_viol, sext_viol, underspeed, timeout_rst, timeout_sticky;

  int tests = 0, fails = 0;
  int start_cnt = 0, stop_cnt = 0, tout_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Wired-AND open-drain bus
  assign scl_i = ~(scl_oe | tb_scl_pull);
  assign sda_i = ~(sda_oe | tb_sda_pull);

  smb_timing_guard #(
    .FILT_LEN(T_FILT), .HOLDOFF_CYC(T_HOLD), .WDOG_CYC(T_WDOG),
    .TIMEOUT_CYC(T_TOUT), .MEXT_CYC(T_MEXT), .SEXT_CYC(T_SEXT), .HALF_CYC(T_HALF)
  ) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .is_master(is_master),
    .scl_drv_req(scl_drv_req), .sda_drv_req(sda_drv_req), .rel_master(rel_master),
    .req_master(req_master), .clr_status(clr_status), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .grant_master(grant_master), .start_det(start_det), .stop_det(stop_det),
    .bus_idle(bus_idle), .wdog_trip(wdog_trip), .mext_viol(mext_viol),
    .sext_viol(sext_viol), .underspeed(underspeed), .timeout_rst(timeout_rst),
    .timeout_sticky(timeout_sticky)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (start_det)   start_cnt <= start_cnt + 1;
      if (stop_det)    stop_cnt  <= stop_cnt + 1;
      if (timeout_rst) tout_cnt  <= tout_cnt + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int glitch_passes(input int w);
    return (w >= T_FILT) ? 1 : 0;
  endfunction

  function automatic int grant_expected(input int j, input int d);
    return (j >= d && j >= T_HOLD + 1) ? 1 : 0;
  endfunction

  task automatic do_start();
    tb_sda_pull = 1'b1; tick(20);
  endtask

  task automatic do_stop();
    tb_scl_pull = 1'b1; tick(10);
    tb_sda_pull = 1'b1; tick(10);
    tb_scl_pull = 1'b0; tick(10);
    tb_sda_pull = 1'b0; tick(20);
  endtask

  task automatic stretch(input int k);
    scl_drv_req = 1'b1; tick(k);
    scl_drv_req = 1'b0; tick(15);
  endtask

  task automatic bus_clock(input int n);
    repeat (n) begin
      tb_scl_pull = 1'b1; tick(15);
      tb_scl_pull = 1'b0; tick(15);
    end
  endtask

  task automatic pulse_clr();
    clr_status = 1'b1; tick(1); clr_status = 1'b0; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s0, p0, run, bad;
    void'($urandom(32'd20240611));
    tick(5); rst = 1'b0; tick(10);

    // R10: reset state
    check("R10 scl_oe", scl_oe, 0);
    check("R10 sda_oe", sda_oe, 0);
    check("R10 grant", grant_master, 0);
    check("R10 bus_idle", bus_idle, 1);
    check("R10 flags", {wdog_trip, mext_viol, sext_viol, underspeed, timeout_rst, timeout_sticky}, 0);

    // R1: start / stop / idle
    s0 = start_cnt; p0 = stop_cnt;
    do_start();
    check("R1 start seen", start_cnt - s0, 1);
    check("R1 busy after start", bus_idle, 0);
    do_stop();
    check("R1 stop seen", stop_cnt - p0, 1);
    check("R1 idle after stop", bus_idle, 1);
    s0 = start_cnt; p0 = stop_cnt;
    tb_scl_pull = 1'b1; tick(10);
    tb_sda_pull = 1'b1; tick(10);
    tb_sda_pull = 1'b0; tick(10);
    tb_scl_pull = 1'b0; tick(20);
    check("R1 sda under scl low", (start_cnt - s0) + (stop_cnt - p0), 0);

    // R2: random-width glitches on SDA with SCL high
    for (int i = 0; i < 16; i++) begin
      int w;
      w = $urandom_range(T_FILT + 2, 1);
      s0 = start_cnt; p0 = stop_cnt;
      tb_sda_pull = 1'b1; tick(w);
      tb_sda_pull = 1'b0; tick(20);
      check($sformatf("R2 glitch w=%0d start", w), start_cnt - s0, glitch_passes(w));
      check($sformatf("R2 glitch w=%0d stop", w), stop_cnt - p0, glitch_passes(w));
    end

    // R3: SCL hold watchdog
    is_master = 1'b0;
    scl_drv_req = 1'b1;
    run = 0;
    for (int j = 0; j < T_WDOG + 30; j++) begin
      tick(1);
      if (scl_oe) run++;
      else if (run != 0) break;
    end
    check("R3 hold length", run, T_WDOG);
    tick(20);
    check("R3 stays released", scl_oe, 0);
    check("R3 trip flag", wdog_trip, 1);
    scl_drv_req = 1'b0; tick(3);
    check("R3 trip clears", wdog_trip, 0);
    tick(20);

    // R4: random request timing against the holdoff gap
    for (int i = 0; i < 8; i++) begin
      int d;
      d = $urandom_range(T_HOLD + 10, 1);
      bad = 0;
      rel_master = 1'b1; tick(1);
      for (int j = 1; j <= T_HOLD + 12; j++) begin
        rel_master = 1'b0;
        req_master = (j >= d);
        tick(1);
        if (int'(grant_master) != grant_expected(j, d)) bad++;
      end
      check($sformatf("R4 holdoff d=%0d mismatches", d), bad, 0);
      req_master = 1'b0; tick(3);
    end

    // R5: master per-byte budget
    is_master = 1'b1; pulse_clr();
    do_start();
    stretch(40);
    bus_clock(9);
    stretch(40);
    check("R5 cleared per byte", mext_viol, 0);
    stretch(30);
    check("R5 budget exceeded", mext_viol, 1);
    check("R7 normal phases", underspeed, 0);
    do_stop();
    pulse_clr();
    check("R9 clr mext", mext_viol, 0);
    do_start();
    stretch(40);
    check("R5 cleared by start", mext_viol, 0);
    do_stop();

    // R6: slave per-message budget
    is_master = 1'b0; pulse_clr();
    do_start();
    stretch(60);
    bus_clock(9);
    stretch(60);
    check("R6 within budget", sext_viol, 0);
    stretch(40);
    check("R6 budget exceeded", sext_viol, 1);
    do_stop();
    pulse_clr();
    do_start();
    stretch(80);
    check("R6 cleared per message", sext_viol, 0);
    do_stop();

    // R7: under-speed only as master
    is_master = 1'b0; pulse_clr();
    do_start(); tick(200);
    check("R7 slave no flag", underspeed, 0);
    do_stop();
    is_master = 1'b1;
    do_start(); tick(200);
    check("R7 master slow phase", underspeed, 1);
    do_stop();
    pulse_clr();
    check("R9 clr underspeed", underspeed, 0);

    // R8/R9/R11: stall timeout with a release in the same cycle
    is_master = 1'b0;
    req_master = 1'b1; tick(3);
    check("R11 grant before", grant_master, 1);
    s0 = tout_cnt;
    do_start();
    tb_sda_pull = 1'b0; sda_drv_req = 1'b1;
    tb_scl_pull = 1'b1;
    for (int j = 0; j < T_TOUT + 60; j++) begin
      tick(1);
      if (timeout_rst) break;
    end
    check("R8 timeout seen", timeout_rst, 1);
    rel_master = 1'b1; tick(1);
    rel_master = 1'b0; tick(2);
    check("R8 sda released", sda_oe, 0);
    tick(10);
    check("R11 holdoff restarted", grant_master, 0);
    tb_scl_pull = 1'b0; tick(20);
    check("R8 single pulse", tout_cnt - s0, 1);
    check("R8 message closed", bus_idle, 1);
    check("R8 sda held off", sda_oe, 0);
    check("R9 sticky set", timeout_sticky, 1);
    tick(T_HOLD);
    check("R11 grant after gap", grant_master, 1);
    sda_drv_req = 1'b0; tick(5);
    check("R9 sticky holds", timeout_sticky, 1);
    pulse_clr();
    check("R9 sticky cleared", timeout_sticky, 0);
    req_master = 1'b0; tick(5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule